// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Registers

This block performs 32x32 integer multiplication and 32/32 integer division for a RISC-style core. It holds its own architectural result pair: HI and LO. A product fills HI:LO as one 64-bit value. A division leaves the quotient in LO and the remainder in HI. The core starts an operation with a one-cycle `start_i` pulse and a 6-bit function code. The unit then works one bit per cycle and holds `busy_o` high until the new HI/LO values are in place.

The same start/function interface also moves values between HI/LO and the core's register file. A move-to writes `op_a_i` into HI or LO. A move-from is answered in the same cycle on a read port. The core's interlock uses `busy_o` to hold move-from requests back while an operation is running. A move-to that arrives during that window is dropped and reported on `err_o`.

Top module: `muldiv_unit`

## Requirements
- R1: After reset HI and LO both read as zero, and `busy_o` and `err_o` are low.
- R2: Function 0x18 multiplies the operands as signed two's-complement values and 0x19 as unsigned values. The low 32 bits of the 64-bit product go to LO and the high 32 bits to HI.
- R3: Function 0x1b divides unsigned, leaving the quotient in LO and the remainder in HI.
- R4: Function 0x1a divides signed. The quotient truncates toward zero and a nonzero remainder has the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R5: A divide, signed or unsigned, with a divisor `op_b_i` of zero sets HI and LO to zero.
- R6: A multiply or divide accepted at a clock edge while idle keeps `busy_o` high for exactly WIDTH+1 cycles (33 by default). HI and LO take the result on the edge where `busy_o` falls.
- R7: While idle, `start_i` with function 0x10 raises `rd_valid_o` in the same cycle with HI on `rd_data_o`, and 0x12 does the same with LO. While busy, `rd_valid_o` stays low.
- R8: While idle, `start_i` with function 0x11 writes `op_a_i` into HI and 0x13 writes it into LO. Either value is readable from the next cycle.
- R9: A move-to (0x11 or 0x13) while busy writes nothing and raises `err_o` for the one following cycle.
- R10: A multiply or divide start while busy is ignored. The running operation's result and latency are unchanged.
- R11: `start_i` with any function code not listed above changes neither HI, LO nor `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe for the function on `func_i` |
| func_i | input | 6 | Function code |
| op_a_i | input | 32 | First operand / move-to data |
| op_b_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Multiply or divide in progress |
| rd_valid_o | output | 1 | Move-from answered this cycle |
| rd_data_o | output | 32 | HI or LO value for a move-from |
| err_o | output | 1 | A move-to was dropped during the previous cycle |

## Verification
The bench goes after sign handling at the edges of the range:
- The most-negative dividend over minus one must wrap to 0x80000000 with a zero remainder. A unit that negated the magnitude at the wrong width would return a wrong quotient or a nonzero HI.
- Mixed-sign divides such as -7/2 and 7/-2 tell truncation toward zero apart from floor division. They also show whether the remainder follows the dividend.
- Squaring 0x80000000 and multiplying 0xFFFFFFFF by itself expose a missing carry out of the 33-bit partial sum.
- Divide by zero is run after HI and LO hold nonzero values, so a unit that skips clearing them keeps stale data.
- Move-to, move-from and new starts are issued in the middle of an operation. A unit that lets a dropped move-to slip through would corrupt HI, and one that restarts on a second start would change the result or the busy count.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam logic [5:0] FN_MFHI = 6'h10;
    localparam logic [5:0] FN_MTHI = 6'h11;
    localparam logic [5:0] FN_MFLO = 6'h12;
    localparam logic [5:0] FN_MTLO = 6'h13;
    localparam logic [5:0] FN_MUL  = 6'h18;
    localparam logic [5:0] FN_MULU = 6'h19;
    localparam logic [5:0] FN_DIV  = 6'h1a;
    localparam logic [5:0] FN_DIVU = 6'h1b;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_mul_step.sv
// One shift-add step on the combined {partial sum, multiplier} register.
module muldiv_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] work_i,
    input  logic [WIDTH-1:0]   mcand_i,
    output logic [2*WIDTH-1:0] work_o
);
    localparam int DW = 2 * WIDTH;

    logic [WIDTH:0] sum;

    always_comb begin
        sum    = {1'b0, work_i[DW-1:WIDTH]} + (work_i[0] ? {1'b0, mcand_i} : '0);
        work_o = {sum, work_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring step on the combined {remainder, dividend/quotient} register.
module muldiv_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] work_i,
    input  logic [WIDTH-1:0]   divisor_i,
    output logic [2*WIDTH-1:0] work_o
);
    localparam int DW = 2 * WIDTH;

    logic [WIDTH:0] trial;

    always_comb begin
        trial = work_i[DW-1:WIDTH-1] - {1'b0, divisor_i};
        if (!trial[WIDTH]) begin
            work_o = {trial[WIDTH-1:0], work_i[WIDTH-2:0], 1'b1};
        end else begin
            work_o = {work_i[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/muldiv_fix.sv
// Applies result signs to the magnitude result and splits it into HI/LO.
module muldiv_fix #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] work_i,
    input  logic               is_div_i,
    input  logic               neg_res_i,
    input  logic               neg_rem_i,
    input  logic               div_zero_i,
    output logic [WIDTH-1:0]   hi_o,
    output logic [WIDTH-1:0]   lo_o
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0]    prod;
    logic [WIDTH-1:0] quo;
    logic [WIDTH-1:0] rem;

    always_comb begin
        prod = neg_res_i ? (~work_i + 1'b1) : work_i;
        quo  = neg_res_i ? (~work_i[WIDTH-1:0] + 1'b1) : work_i[WIDTH-1:0];
        rem  = neg_rem_i ? (~work_i[DW-1:WIDTH] + 1'b1) : work_i[DW-1:WIDTH];
        if (!is_div_i) begin
            hi_o = prod[DW-1:WIDTH];
            lo_o = prod[WIDTH-1:0];
        end else if (div_zero_i) begin
            hi_o = '0;
            lo_o = '0;
        end else begin
            hi_o = rem;
            lo_o = quo;
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
// Architectural HI/LO result pair.
module muldiv_hilo #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi_i,
    input  logic             wr_lo_i,
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    typedef struct packed {
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } hilo_t;

    hilo_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_hi_i) r_d.hi = hi_i;
        if (wr_lo_i) r_d.lo = lo_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hi_o = r_q.hi;
    assign lo_o = r_q.lo;

    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi_i && !wr_lo_i |=> $stable(hi_o) && $stable(lo_o)); // R11
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [5:0]        func_i,
    input  logic [WIDTH-1:0]  op_a_i,
    input  logic [WIDTH-1:0]  op_b_i,
    output logic              busy_o,
    output logic              rd_valid_o,
    output logic [WIDTH-1:0]  rd_data_o,
    output logic              err_o
);
    import muldiv_pkg::*;

    localparam int DW = 2 * WIDTH;
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    typedef struct packed {
        md_state_e        st;
        logic [CW-1:0]    cnt;
        logic [DW-1:0]    work;
        logic [WIDTH-1:0] opnd;
        logic             is_div;
        logic             neg_res;
        logic             neg_rem;
        logic             dz;
        logic             err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             f_mul, f_div, f_signed, f_mt, f_mf;
    logic             neg_a, neg_b;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [DW-1:0]    mul_next, div_next;
    logic [WIDTH-1:0] fix_hi, fix_lo, hi_q, lo_q, hi_in, lo_in;
    logic             wr_hi, wr_lo;

    // Function decode
    always_comb begin
        f_mul    = (func_i == FN_MUL) || (func_i == FN_MULU);
        f_div    = (func_i == FN_DIV) || (func_i == FN_DIVU);
        f_signed = (func_i == FN_MUL) || (func_i == FN_DIV);
        f_mt     = (func_i == FN_MTHI) || (func_i == FN_MTLO);
        f_mf     = (func_i == FN_MFHI) || (func_i == FN_MFLO);
        neg_a    = f_signed && op_a_i[WIDTH-1];
        neg_b    = f_signed && op_b_i[WIDTH-1];
        mag_a    = neg_a ? (~op_a_i + 1'b1) : op_a_i;
        mag_b    = neg_b ? (~op_b_i + 1'b1) : op_b_i;
    end

    muldiv_mul_step #(.WIDTH(WIDTH)) u_mul (
        .work_i (c_q.work),
        .mcand_i(c_q.opnd),
        .work_o (mul_next)
    );

    muldiv_div_step #(.WIDTH(WIDTH)) u_div (
        .work_i   (c_q.work),
        .divisor_i(c_q.opnd),
        .work_o   (div_next)
    );

    muldiv_fix #(.WIDTH(WIDTH)) u_fix (
        .work_i    (c_q.work),
        .is_div_i  (c_q.is_div),
        .neg_res_i (c_q.neg_res),
        .neg_rem_i (c_q.neg_rem),
        .div_zero_i(c_q.dz),
        .hi_o      (fix_hi),
        .lo_o      (fix_lo)
    );

    // Next-state logic
    always_comb begin
        c_d     = c_q;
        c_d.err = start_i && f_mt && (c_q.st != ST_IDLE);
        wr_hi   = 1'b0;
        wr_lo   = 1'b0;
        hi_in   = fix_hi;
        lo_in   = fix_lo;
        unique case (c_q.st)
            ST_IDLE: begin
                hi_in = op_a_i;
                lo_in = op_a_i;
                if (start_i && (f_mul || f_div)) begin
                    c_d.st      = ST_RUN;
                    c_d.cnt     = '0;
                    c_d.is_div  = f_div;
                    c_d.neg_res = neg_a ^ neg_b;
                    c_d.neg_rem = neg_a;
                    c_d.dz      = f_div && (op_b_i == '0);
                    c_d.work    = f_div ? {{WIDTH{1'b0}}, mag_a} : {{WIDTH{1'b0}}, mag_b};
                    c_d.opnd    = f_div ? mag_b : mag_a;
                end else if (start_i && f_mt) begin
                    wr_hi = (func_i == FN_MTHI);
                    wr_lo = (func_i == FN_MTLO);
                end
            end
            ST_RUN: begin
                c_d.work = c_q.is_div ? div_next : mul_next;
                c_d.cnt  = c_q.cnt + 1'b1;
                if (c_q.cnt == LAST_STEP) c_d.st = ST_FIX;
            end
            ST_FIX: begin
                wr_hi  = 1'b1;
                wr_lo  = 1'b1;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    muldiv_hilo #(.WIDTH(WIDTH)) u_hilo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hi_i(wr_hi),
        .wr_lo_i(wr_lo),
        .hi_i   (hi_in),
        .lo_i   (lo_in),
        .hi_o   (hi_q),
        .lo_o   (lo_q)
    );

    assign busy_o     = (c_q.st != ST_IDLE);
    assign err_o      = c_q.err;
    assign rd_valid_o = start_i && f_mf && !busy_o;
    assign rd_data_o  = (func_i == FN_MFHI) ? hi_q : lo_q;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (f_mul || f_div) |=> busy_o); // R6
    AST_MT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && f_mt && (c_q.st == ST_RUN) |=> err_o && $stable(hi_q) && $stable(lo_q)); // R9
    AST_RD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !busy_o); // R7
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RUN) && c_q.is_div && !c_q.dz |-> c_q.work[DW-1:WIDTH] < c_q.opnd); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RUN) && (c_q.cnt != LAST_STEP) |=> (c_q.st == ST_RUN) && (c_q.cnt == $past(c_q.cnt) + 1'b1)); // R10
endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;
    localparam logic [5:0] MFHI = 6'h10, MTHI = 6'h11, MFLO = 6'h12, MTLO = 6'h13;
    localparam logic [5:0] MUL = 6'h18, MULU = 6'h19, DIV = 6'h1a, DIVU = 6'h1b;
    localparam int LAT = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  func = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        busy, rd_valid, err;
    logic [31:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit running = 0;

    always #2.5 clk = ~clk;

    muldiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .func_i(func),
        .op_a_i(op_a), .op_b_i(op_b), .busy_o(busy),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .err_o(err)
    );

    function automatic logic [63:0] ref_calc(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        longint sp;
        int q, r;
        case (f)
            MUL:  begin sp = longint'($signed(a)) * longint'($signed(b)); return sp; end
            MULU: return {32'b0, a} * {32'b0, b};
            DIV: begin
                if (b == 0) return 64'd0;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'h0, 32'h8000_0000};
                q = $signed(a) / $signed(b);
                r = $signed(a) % $signed(b);
                return {r, q};
            end
            DIVU: begin
                if (b == 0) return 64'd0;
                return {a % b, a / b};
            end
            default: return 64'd0;
        endcase
    endfunction

    // Behavioural reference: HI/LO, remaining busy cycles, error flag
    logic [31:0] m_hi, m_lo;
    logic [63:0] m_pend;
    int          m_cnt;
    bit          m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_cnt = 0; m_err = 0; m_pend = 0;
        end else begin
            m_err = 0;
            if (m_cnt > 0) begin
                if (start && (func == MTHI || func == MTLO)) m_err = 1;
                m_cnt--;
                if (m_cnt == 0) {m_hi, m_lo} = m_pend;
            end else if (start) begin
                if (func == MUL || func == MULU || func == DIV || func == DIVU) begin
                    m_pend = ref_calc(func, op_a, op_b);
                    m_cnt = LAT;
                end else if (func == MTHI) m_hi = op_a;
                else if (func == MTLO) m_lo = op_a;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every clock: busy and error flag against the model (R6, R9)
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R6 busy per cycle", {31'b0, busy}, {31'b0, m_cnt > 0});
            chk("R9 err per cycle", {31'b0, err}, {31'b0, m_err});
        end
    end

    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        start = 1; func = f; op_a = a; op_b = b;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_reg(input logic [5:0] f, input logic [31:0] exp, input string tag);
        start = 1; func = f;
        #1;
        chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
        chk(tag, rd_data, exp);
        @(negedge clk);
        start = 0;
    endtask

    task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [63:0] e;
        e = ref_calc(f, a, b);
        issue(f, a, b);
        wait_idle();
        read_reg(MFHI, e[63:32], {tag, " HI"});
        read_reg(MFLO, e[31:0], {tag, " LO"});
    endtask

    task automatic finish_run();
        running = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] s, a, b, sv_hi, sv_lo;
        logic [5:0]  f;
        logic [63:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 err", {31'b0, err}, 32'd0);
        read_reg(MFHI, 32'h0, "R1 HI");
        read_reg(MFLO, 32'h0, "R1 LO");

        // R8 move-to
        issue(MTHI, 32'h1234_5678, 0);
        issue(MTLO, 32'h9ABC_DEF0, 0);
        read_reg(MFHI, 32'h1234_5678, "R8 HI");
        read_reg(MFLO, 32'h9ABC_DEF0, "R8 LO");

        // R2 multiplies
        run_op(MUL, 32'hFFFF_FFFD, 32'd7, "R2 -3*7");
        run_op(MUL, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2 max*max");
        run_op(MUL, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
        run_op(MUL, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
        run_op(MULU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 u max*max");
        run_op(MULU, 32'h8000_0000, 32'd2, "R2 u carry");

        // R3 unsigned divides
        run_op(DIVU, 32'd100, 32'd7, "R3 100/7");
        run_op(DIVU, 32'hFFFF_FFFF, 32'd1, "R3 max/1");
        run_op(DIVU, 32'd5, 32'hFFFF_FFFF, "R3 5/max");

        // R4 signed divides
        run_op(DIV, 32'hFFFF_FFF9, 32'd2, "R4 -7/2");
        run_op(DIV, 32'd7, 32'hFFFF_FFFE, "R4 7/-2");
        run_op(DIV, 32'hFFFF_FFF8, 32'hFFFF_FFFD, "R4 -8/-3");
        issue(DIV, 32'h8000_0000, 32'hFFFF_FFFF);
        wait_idle();
        read_reg(MFLO, 32'h8000_0000, "R4 min/-1 LO");
        read_reg(MFHI, 32'h0000_0000, "R4 min/-1 HI");

        // R5 divide by zero with stale nonzero HI/LO
        issue(MTHI, 32'hAAAA_5555, 0);
        issue(MTLO, 32'h5555_AAAA, 0);
        run_op(DIVU, 32'd1234, 32'd0, "R5 u /0");
        issue(MTHI, 32'h0F0F_0F0F, 0);
        run_op(DIV, 32'h8000_0000, 32'd0, "R5 s /0");

        // R9 / R7 / R10 requests while busy
        e = ref_calc(MUL, 32'hFFFF_FFF0, 32'h10);
        issue(MUL, 32'hFFFF_FFF0, 32'h10);
        issue(MTHI, 32'hDEAD_BEEF, 0);
        chk("R9 err after dropped move-to", {31'b0, err}, 32'd1);
        start = 1; func = MFHI;
        #1;
        chk("R7 no read while busy", {31'b0, rd_valid}, 32'd0);
        @(negedge clk);
        start = 0;
        issue(DIVU, 32'd5, 32'd1);
        wait_idle();
        read_reg(MFHI, e[63:32], "R10 HI kept");
        read_reg(MFLO, e[31:0], "R10 LO kept");

        // R11 unknown function code
        sv_hi = m_hi; sv_lo = m_lo;
        issue(6'h05, 32'h1111_1111, 32'h2222_2222);
        chk("R11 busy", {31'b0, busy}, 32'd0);
        issue(6'h3F, 32'h3333_3333, 32'h0);
        read_reg(MFHI, sv_hi, "R11 HI");
        read_reg(MFLO, sv_lo, "R11 LO");

        // Mixed pseudo-random operations (R2 R3 R4 R5)
        s = 32'hACE1_2024;
        for (int i = 0; i < 24; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            a = s;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            b = (i % 7 == 3) ? 32'd0 : ((i % 3 == 0) ? (s >> (i % 29)) : s);
            case (i % 4)
                0: f = MUL;
                1: f = MULU;
                2: f = DIV;
                default: f = DIVU;
            endcase
            run_op(f, a, b, "R2/R3/R4/R5 mixed");
        end

        // model cross-check of final HI/LO
        read_reg(MFHI, m_hi, "R6 final HI");
        read_reg(MFLO, m_lo, "R6 final LO");
        finish_run();
    end
endmodule